// File: doc/BRIEF.md
# Start-Stop Character Receiver with Overspeed Tolerance

This block frames the bit stream that a demodulator delivers for asynchronous start-stop data. The demodulator presents one sampled line bit together with a one-cycle strobe for each received bit time. The block finds the start bit and collects seven or eight data bits, least significant first, plus an optional parity bit and the stop bit. At the stop bit it loads the character into a data register that the host reads, and it updates four status flags: data ready, overflow, framing error and even parity.

A sender that runs slightly fast may shorten or drop a stop bit. A mode input lets the receiver accept an occasional missing stop bit. A one-bit-per-character history of missing stop bits limits how often this happens: at most one miss in any 8 consecutive characters in the mild mode, or in any 4 in the strong mode. When a miss is accepted, the zero sampled in the stop position becomes the start bit of the next character. A miss that is not accepted raises the framing-error flag, and the receiver waits for a mark bit before it hunts for a start bit again. The host clears the data-ready and overflow flags with a one-cycle read strobe.

Top module: `ssrx_framer`

## Requirements
- R1: Each character is assembled least significant bit first, with 8 data bits when `cfg_len8`=1 and 7 data bits when `cfg_len8`=0; with 7 bits, bit 7 of `rx_data` reads 0. On the stop-bit strobe the character is loaded into `rx_data` and `flag_ready` is set, both visible one cycle later.
- R2: While hunting, strobes that sample 1 are ignored, and the first strobe that samples 0 is taken as the start bit.
- R3: A stop bit sampled as 0 still loads the character and sets `flag_ready`.
- R4: A missing stop bit that the overspeed allowance does not cover sets `flag_ferr`. The receiver then ignores every strobe until one samples 1, and only after that does it hunt for a start bit.
- R5: `flag_ferr` changes only when a character is loaded. It then shows whether that character's stop bit raised a framing error, and a host read leaves it unchanged.
- R6: Loading a character while `flag_ready` is still set, with no read in the same cycle, sets `flag_ovf`.
- R7: `host_rd` clears `flag_ready` and `flag_ovf`. If a read and a load happen in the same cycle, `flag_ready` ends at 1 and `flag_ovf` at 0.
- R8: At each load, `flag_evpar` is set to 1 when the data bits, together with the parity bit if parity is enabled, hold an even number of ones, and to 0 otherwise.
- R9: `cfg_ovs` encoding: 00 means no tolerance, 01 means one miss per 8 characters, 10 means one miss per 4 characters, and 11 behaves like 00. With no tolerance, every missing stop bit is a framing error.
- R10: A tolerated missing stop bit leaves `flag_ferr` at 0, and its zero serves as the start bit of the next character, so the next data bit follows directly.
- R11: A miss is tolerated only if none of the previous N−1 characters (N = 8 for 01, N = 4 for 10) had a missing stop bit. Misses that raised a framing error count as well.
- R12: When `cfg_par_en`=1, exactly one parity bit is received between the last data bit and the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received line bit, sampled when `bit_stb` is high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data bits |
| cfg_ovs | input | 2 | Overspeed tolerance mode (see R9) |
| host_rd | input | 1 | One-cycle host read strobe for the data register |
| rx_data | output | 8 | Last received character |
| flag_ready | output | 1 | Unread character present |
| flag_ovf | output | 1 | A character arrived before the previous one was read |
| flag_ferr | output | 1 | Last character had an untolerated missing stop bit |
| flag_evpar | output | 1 | Last character had even parity over data plus parity bit |

## Verification
The assertions check on every cycle the relations that tie the flags to the framer's state. A stop strobe always raises ready. A read with no load clears ready and overflow. Overflow only rises while a character is still unread. The framing-error flag moves only on a load, and an untolerated miss is always followed by the mark-wait state. With tolerance off, every zero stop bit leads to a framing error. Only the bench scenarios can show the things that depend on a sequence of characters: bit order and 7-bit alignment, where the parity bit sits, the parity flag values, the zeros ignored during mark-wait, and the counting of the sliding window in both tolerance modes, including the exact character at which a second miss falls outside the window.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

  typedef enum logic [2:0] {
    S_HUNT = 3'd0,
    S_DATA = 3'd1,
    S_PAR  = 3'd2,
    S_STOP = 3'd3,
    S_MARK = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    OVS_NONE = 2'b00,
    OVS_WIDE = 2'b01,
    OVS_TIGHT = 2'b10,
    OVS_RSVD = 2'b11
  } ovs_mode_e;

endpackage

// File: rtl/ssrx_shreg.sv
module ssrx_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word
);

  logic [WIDTH-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {din, sh_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;

endmodule

// File: rtl/ssrx_allow.sv
module ssrx_allow #(
  parameter int WIN_WIDE  = 8,
  parameter int WIN_TIGHT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       miss,
  input  logic [1:0] ovs,
  output logic       tolerate
);
  import ssrx_pkg::*;

  localparam int HD = WIN_WIDE - 1;

  logic [HD-1:0] hist_q, hist_d;
  logic          clean_wide, clean_tight;

  assign clean_wide  = ~|hist_q;
  assign clean_tight = ~|hist_q[WIN_TIGHT-2:0];

  always_comb begin
    case (ovs_mode_e'(ovs))
      OVS_WIDE:  tolerate = clean_wide;
      OVS_TIGHT: tolerate = clean_tight;
      default:   tolerate = 1'b0;
    endcase
  end

  always_comb begin
    hist_d = hist_q;
    if (push) hist_d = {hist_q[HD-2:0], miss};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

endmodule

// File: rtl/ssrx_status.sv
module ssrx_status #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  input  logic             ferr_new,
  input  logic             even_new,
  input  logic             host_rd,
  output logic [WIDTH-1:0] rx_data,
  output logic             flag_ready,
  output logic             flag_ovf,
  output logic             flag_ferr,
  output logic             flag_evpar
);

  logic [WIDTH-1:0] data_q, data_d;
  logic rdy_q, rdy_d, ovf_q, ovf_d, ferr_q, ferr_d, ev_q, ev_d;

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    ovf_d  = ovf_q;
    ferr_d = ferr_q;
    ev_d   = ev_q;
    if (host_rd) begin
      rdy_d = 1'b0;
      ovf_d = 1'b0;
    end
    if (load) begin
      data_d = word;
      rdy_d  = 1'b1;
      ferr_d = ferr_new;
      ev_d   = even_new;
      if (rdy_q && !host_rd) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovf_q  <= 1'b0;
      ferr_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      ovf_q  <= ovf_d;
      ferr_q <= ferr_d;
      ev_q   <= ev_d;
    end
  end

  assign rx_data    = data_q;
  assign flag_ready = rdy_q;
  assign flag_ovf   = ovf_q;
  assign flag_ferr  = ferr_q;
  assign flag_evpar = ev_q;

endmodule

// File: rtl/ssrx_framer.sv
module ssrx_framer #(
  parameter int DATA_MAX  = 8,
  parameter int WIN_WIDE  = 8,
  parameter int WIN_TIGHT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                bit_in,
  input  logic                cfg_len8,
  input  logic                cfg_par_en,
  input  logic [1:0]          cfg_ovs,
  input  logic                host_rd,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                flag_ready,
  output logic                flag_ovf,
  output logic                flag_ferr,
  output logic                flag_evpar
);
  import ssrx_pkg::*;

  localparam int CW = $clog2(DATA_MAX + 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DATA_MAX - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DATA_MAX - 2);

  rx_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, last_idx;
  logic par_q, par_d;
  logic shift_en, xfer, miss, tol;
  logic [DATA_MAX-1:0] sh_word, char_word;
  logic even_new;

  assign last_idx = cfg_len8 ? LAST_LONG : LAST_SHORT;

  // next-state logic of the framing sequencer
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    par_d    = par_q;
    shift_en = 1'b0;
    xfer     = 1'b0;
    miss     = 1'b0;
    if (bit_stb) begin
      case (state_q)
        S_HUNT: begin
          if (!bit_in) begin
            state_d = S_DATA;
            cnt_d   = '0;
          end
        end
        S_DATA: begin
          shift_en = 1'b1;
          if (cnt_q == last_idx) state_d = cfg_par_en ? S_PAR : S_STOP;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        S_PAR: begin
          par_d   = bit_in;
          state_d = S_STOP;
        end
        S_STOP: begin
          xfer = 1'b1;
          miss = !bit_in;
          if (bit_in) begin
            state_d = S_HUNT;
          end else if (tol) begin
            state_d = S_DATA;
            cnt_d   = '0;
          end else begin
            state_d = S_MARK;
          end
        end
        S_MARK: begin
          if (bit_in) state_d = S_HUNT;
        end
        default: state_d = S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      par_q   <= par_d;
    end
  end

  ssrx_shreg #(.WIDTH(DATA_MAX)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (bit_in),
    .word     (sh_word)
  );

  assign char_word = cfg_len8 ? sh_word : {1'b0, sh_word[DATA_MAX-1:1]};
  assign even_new  = ~(^char_word ^ (cfg_par_en & par_q));

  ssrx_allow #(.WIN_WIDE(WIN_WIDE), .WIN_TIGHT(WIN_TIGHT)) u_allow (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (xfer),
    .miss     (miss),
    .ovs      (cfg_ovs),
    .tolerate (tol)
  );

  ssrx_status #(.WIDTH(DATA_MAX)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (xfer),
    .word       (char_word),
    .ferr_new   (miss & ~tol),
    .even_new   (even_new),
    .host_rd    (host_rd),
    .rx_data    (rx_data),
    .flag_ready (flag_ready),
    .flag_ovf   (flag_ovf),
    .flag_ferr  (flag_ferr),
    .flag_evpar (flag_evpar)
  );

endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_stb,
  input logic                 bit_in,
  input logic [1:0]           cfg_ovs,
  input logic                 host_rd,
  input logic                 flag_ready,
  input logic                 flag_ovf,
  input logic                 flag_ferr,
  input logic                 xfer,
  input ssrx_pkg::rx_state_e  st
);
  import ssrx_pkg::*;

  p_ready_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && st == S_STOP) |=> flag_ready);

  p_zero_stop_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && st == S_STOP && !bit_in) |=> flag_ready);

  p_mark_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && st == S_STOP && bit_stb && !bit_in && (cfg_ovs == 2'b00 || cfg_ovs == 2'b11))
      |=> (st == S_MARK));

  p_ferr_moves_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer) |=> $stable(flag_ferr));

  p_ovf_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ready && !xfer) |=> !flag_ovf);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !xfer) |=> (!flag_ready && !flag_ovf));

  p_ovs_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && st == S_STOP && !bit_in && (cfg_ovs == 2'b00 || cfg_ovs == 2'b11))
      |=> flag_ferr);

endmodule

bind ssrx_framer ssrx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .bit_in     (bit_in),
  .cfg_ovs    (cfg_ovs),
  .host_rd    (host_rd),
  .flag_ready (flag_ready),
  .flag_ovf   (flag_ovf),
  .flag_ferr  (flag_ferr),
  .xfer       (xfer),
  .st         (state_q)
);

// File: tb/ssrx_framer_bench.sv
module ssrx_framer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, bit_in = 1'b1;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0;
  logic [1:0] cfg_ovs = 2'b00;
  logic host_rd = 1'b0;
  logic [7:0] rx_data;
  logic flag_ready, flag_ovf, flag_ferr, flag_evpar;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssrx_framer u_ssrx_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_ovs(cfg_ovs),
    .host_rd(host_rd), .rx_data(rx_data), .flag_ready(flag_ready),
    .flag_ovf(flag_ovf), .flag_ferr(flag_ferr), .flag_evpar(flag_evpar)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit rd);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1; host_rd = rd;
    @(negedge clk);
    bit_stb = 1'b0; host_rd = 1'b0; bit_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input logic pb, input logic stop,
                           input bit with_start, input bit rd_at_stop);
    if (with_start) send_bit(1'b0, 1'b0);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) send_bit(d[i], 1'b0);
    if (cfg_par_en) send_bit(pb, 1'b0);
    send_bit(stop, rd_at_stop);
  endtask

  function automatic logic exp_even(input logic [7:0] d, input logic pb);
    logic [7:0] m;
    m = cfg_len8 ? d : (d & 8'h7f);
    return ~(^m ^ (cfg_par_en & pb));
  endfunction

  task automatic flush_good();
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) send_char(8'h0f + 8'(i), 1'b0, 1'b1, 1'b1, 1'b0);
    host_read();
  endtask

  task automatic t_reset();
    check("R1 reset ready", {7'b0, flag_ready}, 8'h0);
    check("R6 reset ovf", {7'b0, flag_ovf}, 8'h0);
    check("R5 reset ferr", {7'b0, flag_ferr}, 8'h0);
    check("R1 reset data", rx_data, 8'h00);
  endtask

  task automatic t_basic8();
    cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_ovs = 2'b00;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    check("R2 ones ignored while hunting", {7'b0, flag_ready}, 8'h0);
    send_char(8'hA5, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R1 data 8 bit", rx_data, 8'hA5);
    check("R1 ready set", {7'b0, flag_ready}, 8'h1);
    check("R8 even parity A5", {7'b0, flag_evpar}, {7'b0, exp_even(8'hA5, 1'b0)});
    host_read();
    send_char(8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R1 lsb first", rx_data, 8'h01);
    check("R8 odd parity 01", {7'b0, flag_evpar}, {7'b0, exp_even(8'h01, 1'b0)});
    host_read();
  endtask

  task automatic t_seven_par();
    cfg_len8 = 1'b0; cfg_par_en = 1'b1;
    send_char(8'h35, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R1 R12 data 7 bit with parity", rx_data, 8'h35);
    check("R8 parity bit counted", {7'b0, flag_evpar}, {7'b0, exp_even(8'h35, 1'b1)});
    check("R6 no overflow first", {7'b0, flag_ovf}, 8'h0);
    send_char(8'h4B, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R12 second char", rx_data, 8'h4B);
    check("R6 overflow on unread", {7'b0, flag_ovf}, 8'h1);
    check("R8 parity second", {7'b0, flag_evpar}, {7'b0, exp_even(8'h4B, 1'b0)});
    host_read();
    check("R7 read clears ready", {7'b0, flag_ready}, 8'h0);
    check("R7 read clears ovf", {7'b0, flag_ovf}, 8'h0);
    cfg_len8 = 1'b1; cfg_par_en = 1'b0;
  endtask

  task automatic t_ferr_none();
    cfg_ovs = 2'b00;
    send_char(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 data loaded on zero stop", rx_data, 8'h3C);
    check("R3 ready on zero stop", {7'b0, flag_ready}, 8'h1);
    check("R4 R9 ferr with no tolerance", {7'b0, flag_ferr}, 8'h1);
    host_read();
    check("R5 ferr survives read", {7'b0, flag_ferr}, 8'h1);
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0);
    check("R4 zeros ignored in mark wait", {7'b0, flag_ready}, 8'h0);
    send_bit(1'b1, 1'b0);
    send_char(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R4 resync data", rx_data, 8'h5A);
    check("R5 ferr cleared by next char", {7'b0, flag_ferr}, 8'h0);
    host_read();
  endtask

  task automatic t_ovs_wide();
    cfg_ovs = 2'b01;
    flush_good();
    send_char(8'h11, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 tolerated miss data", rx_data, 8'h11);
    check("R10 tolerated miss no ferr", {7'b0, flag_ferr}, 8'h0);
    host_read();
    send_char(8'h81, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 stop zero used as start", rx_data, 8'h81);
    host_read();
    for (int i = 0; i < 5; i++) send_char(8'h20 + 8'(i), 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h22, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 second miss inside 8", {7'b0, flag_ferr}, 8'h1);
    host_read();
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 7; i++) send_char(8'h30 + 8'(i), 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h44, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 miss just outside 8 window", {7'b0, flag_ferr}, 8'h0);
    host_read();
    send_char(8'h99, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 follow char after window", rx_data, 8'h99);
    host_read();
  endtask

  task automatic t_ovs_tight();
    cfg_ovs = 2'b10;
    flush_good();
    send_char(8'h61, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 R10 tight tolerated", {7'b0, flag_ferr}, 8'h0);
    send_char(8'h62, 1'b0, 1'b1, 1'b0, 1'b0);
    send_char(8'h63, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h64, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 second miss inside 4", {7'b0, flag_ferr}, 8'h1);
    check("R11 data still loaded", rx_data, 8'h64);
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send_char(8'h70 + 8'(i), 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h7E, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 miss just outside 4 window", {7'b0, flag_ferr}, 8'h0);
    send_char(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 tight follow char", rx_data, 8'hC3);
    host_read();
  endtask

  task automatic t_ovs_rsvd();
    cfg_ovs = 2'b11;
    flush_good();
    send_char(8'h18, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 code 11 acts as none", {7'b0, flag_ferr}, 8'h1);
    host_read();
    send_bit(1'b1, 1'b0);
    cfg_ovs = 2'b00;
  endtask

  task automatic t_read_same_cycle();
    send_char(8'h0A, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char(8'h0B, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 overflow set", {7'b0, flag_ovf}, 8'h1);
    send_char(8'h0C, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R7 same cycle ready stays", {7'b0, flag_ready}, 8'h1);
    check("R7 same cycle ovf cleared", {7'b0, flag_ovf}, 8'h0);
    check("R7 same cycle data", rx_data, 8'h0C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic8();
    t_seven_par();
    t_ferr_none();
    t_ovs_wide();
    t_ovs_tight();
    t_ovs_rsvd();
    t_read_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule